// File: doc/BRIEF.md
# Store Address Window Guard

The guard sits between a processor's store path and memory. Every write request carries an 18-bit word address, and the guard compares it with two boundary addresses held in a 64-bit control word that software loads through a write port. A single mode bit in that word decides what is protected. In one setting, the addresses between the bounds are protected. In the other, everything outside that window is protected.

A write to a protected address is blocked: the memory write enable stays low and the guard raises a violation strobe for the interrupt logic. Reads are never checked. The decision is combinational against registered bounds, so grant, write enable and violation all answer in the same cycle as the request. A newly written control word governs requests from the following cycle onward.

Top module: `store_guard`

## Requirements
- R1: After reset both bounds are zero and the mode bit is zero (inside mode). Until the control word is written, every request is granted and no violation is raised.
- R2: In the control word, the upper bound is bits [63:46] (bit 63 is its most significant bit), the lower bound is bits [31:14] (bit 31 is its most significant bit), and the mode bit is bit [6]. All other bits of the word are ignored.
- R3: With mode bit 0 (inside mode), a write is protected exactly when lower <= address < upper, compared as unsigned numbers.
- R4: With mode bit 1 (outside mode), a write is protected exactly when the address is not in lower <= address < upper. If the window is empty, every write is protected.
- R5: When lower >= upper, the window is empty. In inside mode no write is protected.
- R6: A request with the write flag low (a read) is always granted. It never raises a violation and never drives the memory write enable.
- R7: A protected write drives grant low, memory write enable low and the violation strobe high, all in the request cycle.
- R8: An unprotected write drives grant high, memory write enable high and the violation strobe low, all in the request cycle. With no valid request, all three outputs are low.
- R9: A control word written on a clock edge governs requests from that edge onward. A request in the same cycle as the write is judged against the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the control word on this edge |
| cfg_wdata | input | 64 | Control word value |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = store, 0 = read |
| req_addr | input | 18 | Word address of the request |
| req_grant | output | 1 | Request may complete |
| mem_we | output | 1 | Write enable towards memory |
| prot_viol | output | 1 | Protection violation strobe for interrupt logic |

## Verification
All state in the guard lives in the two bound registers and the mode flag, so any corruption shows at the ports. It appears as a wrong grant or violation in the same cycle as a store whose address lies next to one of the bounds. The bench therefore probes each bound at the address just below it, at the bound itself and just above it, in both modes. A wrong field position in the control-word decode, or a register that loads one edge late, changes the verdict on the first request after the write.

// File: rtl/store_guard_pkg.sv
// Package: shared constants and types for the store address window guard.
// Assumes: bit positions given in most-significant-first numbering.
package store_guard_pkg;
    localparam int SG_ADDR_W   = 18;
    localparam int SG_WORD_W   = 64;
    localparam int SG_UP_POS   = 0;   // first (most significant) bit of upper bound
    localparam int SG_LO_POS   = 32;  // first bit of lower bound
    localparam int SG_MODE_POS = 57;  // mode bit

    typedef enum logic {
        WIN_INSIDE  = 1'b0,
        WIN_OUTSIDE = 1'b1
    } win_mode_e;
endpackage

// File: rtl/store_guard_ctlreg.sv
// Module: holds the bound pair and mode decoded from the control word.
// Assumes: field positions are given most-significant-first, so position p maps
// to vector index WORD_W-1-p; reset is synchronous and active low.
module store_guard_ctlreg
    import store_guard_pkg::*;
#(
    parameter int WORD_W   = SG_WORD_W,
    parameter int ADDR_W   = SG_ADDR_W,
    parameter int UP_POS   = SG_UP_POS,
    parameter int LO_POS   = SG_LO_POS,
    parameter int MODE_POS = SG_MODE_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] upper_q,
    output logic [ADDR_W-1:0] lower_q,
    output win_mode_e         mode_q
);
    localparam int UP_LSB  = WORD_W - UP_POS - ADDR_W;
    localparam int LO_LSB  = WORD_W - LO_POS - ADDR_W;
    localparam int MODE_IX = WORD_W - 1 - MODE_POS;

    // Load bounds and mode on a write, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            lower_q <= '0;
            mode_q  <= WIN_INSIDE;
        end else if (cfg_we) begin
            upper_q <= cfg_wdata[UP_LSB +: ADDR_W];
            lower_q <= cfg_wdata[LO_LSB +: ADDR_W];
            mode_q  <= win_mode_e'(cfg_wdata[MODE_IX]);
        end
    end
endmodule

// File: rtl/store_guard_cmp.sv
// Module: decides whether an address is protected under the current bounds.
// Assumes: unsigned compare, window is lower <= addr < upper (empty if lower >= upper).
module store_guard_cmp
    import store_guard_pkg::*;
#(
    parameter int ADDR_W = SG_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] upper,
    input  logic [ADDR_W-1:0] lower,
    input  win_mode_e         mode,
    output logic              protect
);
    logic at_or_above_lo;
    logic below_up;

    // Window membership and mode selection.
    always_comb begin
        at_or_above_lo = (addr >= lower);
        below_up       = (addr < upper);
        protect        = (at_or_above_lo && below_up) ^ (mode == WIN_OUTSIDE);
    end
endmodule

// File: rtl/store_guard_resp.sv
// Module: turns the protection verdict into grant, write enable and violation.
// Assumes: only stores are checked; outputs are combinational in the request cycle.
module store_guard_resp (
    input  logic req_valid,
    input  logic req_write,
    input  logic protect,
    output logic req_grant,
    output logic mem_we,
    output logic prot_viol
);
    // Gate the store and flag violating ones.
    always_comb begin
        prot_viol = req_valid && req_write && protect;
        mem_we    = req_valid && req_write && !protect;
        req_grant = req_valid && !prot_viol;
    end
endmodule

// File: rtl/store_guard.sv
// Module: top of the store address window guard.
// Assumes: bounds are registered, the verdict is combinational on the request.
module store_guard
    import store_guard_pkg::*;
#(
    parameter int WORD_W   = SG_WORD_W,
    parameter int ADDR_W   = SG_ADDR_W,
    parameter int UP_POS   = SG_UP_POS,
    parameter int LO_POS   = SG_LO_POS,
    parameter int MODE_POS = SG_MODE_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_grant,
    output logic              mem_we,
    output logic              prot_viol
);
    logic [ADDR_W-1:0] upper_q;
    logic [ADDR_W-1:0] lower_q;
    win_mode_e         mode_q;
    logic              protect;

    store_guard_ctlreg #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .UP_POS(UP_POS),
        .LO_POS(LO_POS), .MODE_POS(MODE_POS)
    ) u_ctlreg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .upper_q(upper_q), .lower_q(lower_q), .mode_q(mode_q)
    );

    store_guard_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .addr(req_addr), .upper(upper_q), .lower(lower_q),
        .mode(mode_q), .protect(protect)
    );

    store_guard_resp u_resp (
        .req_valid(req_valid), .req_write(req_write), .protect(protect),
        .req_grant(req_grant), .mem_we(mem_we), .prot_viol(prot_viol)
    );
endmodule

// File: rtl/store_guard_chk.sv
// Checker: port-level properties of the guard, bound to every instance.
module store_guard_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_grant,
    input logic              mem_we,
    input logic              prot_viol
);
    logic cfg_seen;

    // Track whether a control word has been loaded since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_seen <= 1'b0;
        else if (cfg_we) cfg_seen <= 1'b1;
    end

    assert_reset_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_seen |-> !prot_viol);

    assert_read_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> (req_grant && !prot_viol && !mem_we));

    assert_viol_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prot_viol |-> (!mem_we && !req_grant));

    assert_store_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> (mem_we != prot_viol));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!req_grant && !mem_we && !prot_viol));

    assert_steady_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && $past(req_valid) && $past(req_write) &&
         $past(rst_n) && $stable(req_addr) && !$past(cfg_we)) |-> $stable(prot_viol));
endmodule

bind store_guard store_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_grant(req_grant),
    .mem_we(mem_we), .prot_viol(prot_viol)
);

// File: tb/store_guard_bench.sv
module store_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 18;
    localparam logic [AW-1:0] AMAX = {AW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [63:0]   cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_grant, mem_we, prot_viol;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    store_guard u_store_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_grant(req_grant), .mem_we(mem_we), .prot_viol(prot_viol)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycles=%0d expected <100000", cycles);
            summary();
        end
    end

    function automatic logic [63:0] word(input logic [AW-1:0] up, input logic [AW-1:0] lo,
                                         input logic md, input logic junk);
        logic [63:0] w;
        w = junk ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0;
        w[63:46] = up;
        w[31:14] = lo;
        w[6]     = md;
        return w;
    endfunction

    // Load a control word: driven at falling edge, captured on the next rising edge.
    task automatic load(input logic [AW-1:0] up, input logic [AW-1:0] lo,
                        input logic md, input logic junk);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = word(up, lo, md, junk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive a request at the falling edge and compare outputs shortly after.
    task automatic probe(input logic v, input logic wr, input logic [AW-1:0] a,
                         input logic eg, input logic ewe, input logic ev, input string rq);
        req_valid = v; req_write = wr; req_addr = a;
        #1;
        n_cmp++;
        if (req_grant !== eg || mem_we !== ewe || prot_viol !== ev) begin
            n_bad++;
            $display("FAIL %s addr=%0d: actual g/we/v=%b%b%b expected %b%b%b",
                     rq, a, req_grant, mem_we, prot_viol, eg, ewe, ev);
        end
        @(negedge clk);
    endtask

    function automatic logic expect_prot(input logic [AW-1:0] a, input logic [AW-1:0] up,
                                         input logic [AW-1:0] lo, input logic md);
        logic inwin;
        inwin = (a >= lo) && (a < up);
        return inwin ^ md;
    endfunction

    task automatic store_check(input logic [AW-1:0] a, input logic [AW-1:0] up,
                               input logic [AW-1:0] lo, input logic md, input string rq);
        logic p;
        p = expect_prot(a, up, lo, md);
        probe(1'b1, 1'b1, a, !p, !p, p, rq);
    endtask

    logic [AW-1:0] pts [6];

    initial begin
        pts[0] = 18'd0;      pts[1] = 18'd1;     pts[2] = 18'd100;
        pts[3] = 18'd131072; pts[4] = 18'd200000; pts[5] = AMAX;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: after reset, everything passes.
        probe(1'b1, 1'b1, 18'd0, 1'b1, 1'b1, 1'b0, "R1");
        probe(1'b1, 1'b1, AMAX, 1'b1, 1'b1, 1'b0, "R1");
        probe(1'b1, 1'b1, 18'd77, 1'b1, 1'b1, 1'b0, "R1");
        // R8: idle gives all zeros.
        probe(1'b0, 1'b1, 18'd5, 1'b0, 1'b0, 1'b0, "R8");

        // R3 R4 R5: sweep bound pairs, both modes, addresses around each bound.
        for (int iu = 0; iu < 6; iu++) begin
            for (int il = 0; il < 6; il++) begin
                for (int m = 0; m < 2; m++) begin
                    load(pts[iu], pts[il], m[0], 1'b0);
                    for (int k = 0; k < 6; k++) begin
                        store_check(pts[k], pts[iu], pts[il], m[0],
                                    (pts[il] >= pts[iu]) ? "R5" : (m == 0 ? "R3" : "R4"));
                        store_check(pts[k] + 18'd1, pts[iu], pts[il], m[0], m == 0 ? "R3" : "R4");
                        store_check(pts[k] - 18'd1, pts[iu], pts[il], m[0], m == 0 ? "R3" : "R4");
                    end
                    // R6: reads always pass, no write enable.
                    probe(1'b1, 1'b0, pts[il], 1'b1, 1'b0, 1'b0, "R6");
                    // R8: idle cycle quiet even with a protecting setup.
                    probe(1'b0, 1'b1, pts[il], 1'b0, 1'b0, 1'b0, "R8");
                end
            end
        end

        // R2: all other bits set, fields still decode at their positions.
        load(18'd1000, 18'd500, 1'b0, 1'b1);
        store_check(18'd499, 18'd1000, 18'd500, 1'b0, "R2");
        store_check(18'd500, 18'd1000, 18'd500, 1'b0, "R2");
        store_check(18'd999, 18'd1000, 18'd500, 1'b0, "R2");
        store_check(18'd1000, 18'd1000, 18'd500, 1'b0, "R2");
        // R2: upper bound MSB at bit 63, lower bound MSB at bit 31.
        load(18'h20000, 18'h1FFFF, 1'b0, 1'b0);
        store_check(18'h1FFFF, 18'h20000, 18'h1FFFF, 1'b0, "R2");
        store_check(18'h20000, 18'h20000, 18'h1FFFF, 1'b0, "R2");
        store_check(18'h1FFFE, 18'h20000, 18'h1FFFF, 1'b0, "R2");

        // R7: outside mode with an empty window blocks every store.
        load(18'd0, 18'd0, 1'b1, 1'b0);
        probe(1'b1, 1'b1, 18'd12345, 1'b0, 1'b0, 1'b1, "R7");
        probe(1'b1, 1'b0, 18'd12345, 1'b1, 1'b0, 1'b0, "R6");

        // R9: request in the write cycle uses the old word; next cycle the new one.
        cfg_we = 1'b1;
        cfg_wdata = word(18'd0, 18'd0, 1'b0, 1'b0);
        probe(1'b1, 1'b1, 18'd42, 1'b0, 1'b0, 1'b1, "R9");
        cfg_we = 1'b0;
        probe(1'b1, 1'b1, 18'd42, 1'b1, 1'b1, 1'b0, "R9");

        // R1: reset again restores the open state.
        load(18'd10, 18'd0, 1'b0, 1'b0);
        probe(1'b1, 1'b1, 18'd3, 1'b0, 1'b0, 1'b1, "R3");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe(1'b1, 1'b1, 18'd3, 1'b1, 1'b1, 1'b0, "R1");

        summary();
    end
endmodule